// File: doc/BRIEF.md
# Floppy Drive Track Emulator

This block sits on a CPU's I/O bus and behaves like a read-only floppy disk controller. Software moves the emulated head by switching four stepper phases on and off through I/O strobes. The block rebuilds the head position in half-track steps from those events, and shows the whole-track number on its own output.

Whenever the whole-track number differs from the track held in the on-chip buffer, the block fetches the new track image from an external block loader. The image arrives as a fixed number of 256-byte blocks. Each block is asked for through a request/acknowledge handshake and then streamed in, one byte per valid cycle. Once the buffer is full, CPU reads of the data location return buffer bytes in order. A read pointer wraps at the end of the track, which imitates the spinning disk. A simple motor enable gates the reads.

The load controller is a three-state machine:
- `LD_REQ` waits for the acknowledge.
- `LD_FILL` accepts the bytes of one block.
- `LD_READY` serves CPU reads.

Its transitions are:
- reset enters `LD_REQ` for track 0, block 0.
- *ack* takes `LD_REQ` to `LD_FILL`.
- *block done* takes `LD_FILL` back to `LD_REQ` for the next block.
- *track done* takes `LD_FILL` to `LD_READY` after the last block.
- *track moved* takes `LD_READY` to `LD_REQ`, block 0. It latches the new track number.

Top module: `flop_track_emu`

## Requirements
- R1: After reset the head is at half-track 0 (`head_track` = 0), the motor is off, `ld_req` is high with `ld_track` = 0 and `ld_block` = 0, and `io_rd_data` is 0.
- R2: The head position is a half-track count from 0 to 2*TRACKS-1 (0 to 69 by default), and `head_track` equals that count divided by two. A phase-on event for phase number (half mod 4)+1 (modulo 4) increments the count, and it saturates at the top.
- R3: A phase-on event for phase number (half mod 4)-1 (modulo 4) decrements the count, saturating at 0. Phase-off events, and phase-on events for any other phase, leave the position unchanged.
- R4: I/O offset decoding on `io_addr` when `io_sel` is high:
  - Offsets 0 to 7 address phase `io_addr[2:1]`. Bit 0 set means on; bit 0 clear means off.
  - Offset 8 turns the motor off, and offset 9 turns it on.
  - Offset 12 is the data location.
  - Offsets 10, 11, 13, 14 and 15 change nothing.
- R5: `ld_req` stays high until a cycle with `ld_ack` high, and `ld_track` and `ld_block` hold steady while it waits.
- R6: After an acknowledge, exactly 256 bytes qualified by `ld_valid` are stored as block `ld_block`, at buffer offset block*256 + index. Blocks are requested in increasing order from 0. After the last block, `ld_req` is low in the following cycle.
- R7: When `head_track` differs from the buffered track, the block starts a reload from block 0 with `ld_track` set to the new track. A track change made during a load causes a further reload once that load ends.
- R8: While a load is in progress, a data read returns 0 and does not move the read pointer.
- R9: With the buffer loaded and the motor on, a data read returns, in the cycle after the strobe, the byte at the read pointer. The pointer then advances and wraps to 0 after the last byte of the track. Each completed load restarts the pointer at 0.
- R10: With the motor off, data reads return 0 and leave the read pointer where it is.
- R11: `io_rd_data` is 0 in every cycle that does not follow a valid data read, including after strobes to other offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | One-cycle I/O access strobe |
| io_addr | input | 4 | I/O offset of the access |
| io_rd_data | output | 8 | Read data, valid the cycle after a data strobe, otherwise 0 |
| ld_req | output | 1 | Block load request |
| ld_ack | input | 1 | Loader accepts the pending request |
| ld_track | output | 6 | Track number of the requested block |
| ld_block | output | $clog2(TRACK_BLOCKS) | Block index within the track |
| ld_valid | input | 1 | A block byte is present on `ld_byte` |
| ld_byte | input | 8 | Block byte, in increasing index order |
| head_track | output | 6 | Current whole-track head position |

## Verification
The checks assume that the loader raises `ld_ack` only while `ld_req` is high, and `ld_valid` only after an acknowledge and never for more bytes than one block holds. The bench loader waits for the request, delays its acknowledge by a random number of cycles, then streams exactly one block with random idle gaps. CPU strobes are single-cycle and separated by idle cycles, so every read result can be sampled before the next strobe. Random phase events come from a fixed seed; directed sequences drive the head against both travel limits.

// File: rtl/flop_pkg.sv
package flop_pkg;
    // load controller states
    typedef enum logic [1:0] {
        LD_REQ   = 2'd0,
        LD_FILL  = 2'd1,
        LD_READY = 2'd2
    } ld_state_t;

    // I/O offsets outside the phase window
    localparam logic [3:0] OFS_MOTOR_OFF = 4'd8;
    localparam logic [3:0] OFS_MOTOR_ON  = 4'd9;
    localparam logic [3:0] OFS_DATA      = 4'd12;
endpackage

// File: rtl/flop_head_stepper.sv
module flop_head_stepper #(
    parameter int TRACKS = 35,
    localparam int HW = $clog2(2 * TRACKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic [1:0]    phase,
    output logic [HW-1:0] half_o
);
    localparam logic [HW-1:0] HALF_TOP = HW'(2 * TRACKS - 1);

    logic [HW-1:0] half_q, half_d;
    logic [1:0]    cur;

    assign cur = half_q[1:0];

    always_comb begin
        half_d = half_q;
        if (step_en) begin
            if (phase == cur + 2'd1 && half_q != HALF_TOP)
                half_d = half_q + 1'b1;
            else if (phase == cur - 2'd1 && half_q != '0)
                half_d = half_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= '0;
        else        half_q <= half_d;
    end

    assign half_o = half_q;
endmodule

// File: rtl/flop_track_ram.sv
module flop_track_ram #(
    parameter int DEPTH = 3072,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/flop_load_fsm.sv
module flop_load_fsm
    import flop_pkg::*;
#(
    parameter int TW = 6,
    parameter int BLK_BYTES = 256,
    parameter int TRACK_BLOCKS = 12,
    localparam int BW  = $clog2(BLK_BYTES),
    localparam int BKW = (TRACK_BLOCKS > 1) ? $clog2(TRACK_BLOCKS) : 1,
    localparam int AW  = $clog2(BLK_BYTES * TRACK_BLOCKS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  cur_track,
    input  logic           ld_ack,
    input  logic           ld_valid,
    input  logic [7:0]     ld_byte,
    output logic           ld_req,
    output logic [TW-1:0]  ld_track,
    output logic [BKW-1:0] ld_block,
    output logic           we,
    output logic [AW-1:0]  waddr,
    output logic [7:0]     wdata,
    output logic           ready
);
    ld_state_t state_q, state_d;
    logic [TW-1:0]  tgt_q;
    logic [BKW-1:0] blk_q;
    logic [BW-1:0]  cnt_q;
    logic           blk_end, trk_end;

    assign blk_end = ld_valid && (cnt_q == BW'(BLK_BYTES - 1));
    assign trk_end = blk_q == BKW'(TRACK_BLOCKS - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_REQ:   if (ld_ack) state_d = LD_FILL;
            LD_FILL:  if (blk_end) state_d = trk_end ? LD_READY : LD_REQ;
            LD_READY: if (cur_track != tgt_q) state_d = LD_REQ;
            default:  state_d = LD_REQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_REQ;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            blk_q <= '0;
            cnt_q <= '0;
        end else if (state_q == LD_READY && state_d == LD_REQ) begin
            tgt_q <= cur_track;
            blk_q <= '0;
            cnt_q <= '0;
        end else if (state_q == LD_FILL && ld_valid) begin
            cnt_q <= cnt_q + 1'b1;
            if (blk_end && !trk_end) blk_q <= blk_q + 1'b1;
        end
    end

    always_comb begin
        ld_req   = state_q == LD_REQ;
        ready    = state_q == LD_READY;
        we       = state_q == LD_FILL && ld_valid;
        ld_track = tgt_q;
        ld_block = blk_q;
        waddr    = AW'(int'(blk_q) * BLK_BYTES + int'(cnt_q));
        wdata    = ld_byte;
    end
endmodule

// File: rtl/flop_track_emu.sv
module flop_track_emu
    import flop_pkg::*;
#(
    parameter int TRACKS = 35,
    parameter int BLK_BYTES = 256,
    parameter int TRACK_BLOCKS = 12,
    localparam int HW  = $clog2(2 * TRACKS),
    localparam int TW  = HW - 1,
    localparam int BKW = (TRACK_BLOCKS > 1) ? $clog2(TRACK_BLOCKS) : 1,
    localparam int LEN = BLK_BYTES * TRACK_BLOCKS,
    localparam int AW  = $clog2(LEN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           io_sel,
    input  logic [3:0]     io_addr,
    output logic [7:0]     io_rd_data,
    output logic           ld_req,
    input  logic           ld_ack,
    output logic [TW-1:0]  ld_track,
    output logic [BKW-1:0] ld_block,
    input  logic           ld_valid,
    input  logic [7:0]     ld_byte,
    output logic [TW-1:0]  head_track
);
    logic [HW-1:0] half_q;
    logic          step_en, rd_go, ready, we, motor_q, hit_q;
    logic [AW-1:0] waddr, ptr_q;
    logic [7:0]    wdata, ram_q;

    assign step_en = io_sel && !io_addr[3] && io_addr[0];
    assign rd_go   = io_sel && io_addr == OFS_DATA && ready && motor_q;

    flop_head_stepper #(.TRACKS(TRACKS)) u_step (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .phase(io_addr[2:1]), .half_o(half_q)
    );

    assign head_track = half_q[HW-1:1];

    flop_load_fsm #(.TW(TW), .BLK_BYTES(BLK_BYTES), .TRACK_BLOCKS(TRACK_BLOCKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cur_track(head_track),
        .ld_ack(ld_ack), .ld_valid(ld_valid), .ld_byte(ld_byte),
        .ld_req(ld_req), .ld_track(ld_track), .ld_block(ld_block),
        .we(we), .waddr(waddr), .wdata(wdata), .ready(ready)
    );

    flop_track_ram #(.DEPTH(LEN)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(ptr_q), .rdata(ram_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                                motor_q <= 1'b0;
        else if (io_sel && io_addr == OFS_MOTOR_ON)  motor_q <= 1'b1;
        else if (io_sel && io_addr == OFS_MOTOR_OFF) motor_q <= 1'b0;
    end

    // rotation: pointer parked at 0 until the buffer is complete
    always_ff @(posedge clk) begin
        if (!rst_n || !ready) ptr_q <= '0;
        else if (rd_go)       ptr_q <= (ptr_q == AW'(LEN - 1)) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= rd_go;
    end

    assign io_rd_data = hit_q ? ram_q : 8'h00;
endmodule

// File: rtl/flop_track_emu_chk.sv
module flop_track_emu_chk #(
    parameter int TRACKS = 35,
    parameter int TRACK_BLOCKS = 12,
    localparam int HW  = $clog2(2 * TRACKS),
    localparam int TW  = HW - 1,
    localparam int BKW = (TRACK_BLOCKS > 1) ? $clog2(TRACK_BLOCKS) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           io_sel,
    input logic [7:0]     io_rd_data,
    input logic           ld_req,
    input logic           ld_ack,
    input logic [TW-1:0]  ld_track,
    input logic [BKW-1:0] ld_block,
    input logic [TW-1:0]  head_track,
    input logic [HW-1:0]  half
);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req && !ld_ack |=> ld_req);

    assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req && !ld_ack |=> $stable(ld_track) && $stable(ld_block));

    assert_half_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        half <= HW'(2 * TRACKS - 1));

    assert_quiet_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !io_sel |=> $stable(head_track));

    assert_load_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> io_rd_data == 8'h00);

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_sel |=> io_rd_data == 8'h00);
endmodule

bind flop_track_emu flop_track_emu_chk #(.TRACKS(TRACKS), .TRACK_BLOCKS(TRACK_BLOCKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_rd_data(io_rd_data),
    .ld_req(ld_req), .ld_ack(ld_ack), .ld_track(ld_track), .ld_block(ld_block),
    .head_track(head_track), .half(half_q)
);

// File: tb/sim_flop_track_emu.sv
module sim_flop_track_emu;
    localparam int BLK = 256;
    localparam int NBLK = 2;
    localparam int LEN = BLK * NBLK;
    localparam int HMAX = 69;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_sel = 1'b0;
    logic [3:0] io_addr = 4'd0;
    logic [7:0] io_rd_data;
    logic       ld_req, ld_ack = 1'b0, ld_valid = 1'b0;
    logic [5:0] ld_track, head_track;
    logic [0:0] ld_block;
    logic [7:0] ld_byte = 8'd0;

    int errs = 0, checks = 0;
    int exp_half = 0, exp_ptr = 0, loaded_trk = 0;

    always #2 clk = ~clk;

    flop_track_emu #(.TRACKS(35), .BLK_BYTES(BLK), .TRACK_BLOCKS(NBLK)) u0 (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_addr(io_addr),
        .io_rd_data(io_rd_data), .ld_req(ld_req), .ld_ack(ld_ack),
        .ld_track(ld_track), .ld_block(ld_block), .ld_valid(ld_valid),
        .ld_byte(ld_byte), .head_track(head_track)
    );

    function automatic logic [7:0] pat(int trk, int idx);
        return 8'((trk * 53 + idx * 7 + (idx >> 3)) ^ 8'h5A);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic io(int a);
        @(negedge clk); io_sel = 1'b1; io_addr = 4'(a);
        @(negedge clk); io_sel = 1'b0;
    endtask

    task automatic phase_op(int p, bit on);
        int cur;
        io(p * 2 + int'(on));
        cur = exp_half % 4;
        if (on) begin
            if (p == (cur + 1) % 4 && exp_half < HMAX) exp_half++;
            else if (p == (cur + 3) % 4 && exp_half > 0) exp_half--;
        end
        check(int'(head_track) == exp_half / 2, "R2/R3 head", int'(head_track), exp_half / 2);
    endtask

    task automatic step_up();   phase_op((exp_half + 1) % 4, 1'b1); endtask
    task automatic step_down(); phase_op((exp_half + 3) % 4, 1'b1); endtask

    task automatic read_data(bit valid, string req);
        io(12);
        if (valid) begin
            check(io_rd_data == pat(loaded_trk, exp_ptr), req, int'(io_rd_data),
                  int'(pat(loaded_trk, exp_ptr)));
            exp_ptr = (exp_ptr + 1) % LEN;
        end else begin
            check(io_rd_data == 8'h00, req, int'(io_rd_data), 0);
        end
    endtask

    task automatic serve_block(int b, int t);
        int n = 0;
        while (!ld_req && n < 50) begin @(negedge clk); n++; end
        check(ld_req == 1'b1, "R6 request", int'(ld_req), 1);
        check(int'(ld_block) == b, "R6 block order", int'(ld_block), b);
        check(int'(ld_track) == t, "R5 track held", int'(ld_track), t);
        repeat ($urandom % 4) begin
            @(negedge clk);
            check(ld_req == 1'b1, "R5 req held", int'(ld_req), 1);
        end
        ld_ack = 1'b1;
        @(negedge clk); ld_ack = 1'b0;
        for (int i = 0; i < BLK; i++) begin
            if ($urandom % 3 == 0) begin ld_valid = 1'b0; @(negedge clk); end
            ld_valid = 1'b1;
            ld_byte  = pat(t, b * BLK + i);
            @(negedge clk);
        end
        ld_valid = 1'b0;
    endtask

    task automatic serve_track(int exp_trk);
        int t;
        bit again;
        do begin
            t = int'(ld_track);
            for (int b = 0; b < NBLK; b++) serve_block(b, t);
            check(ld_req == 1'b0, "R6 done", int'(ld_req), 0);
            @(negedge clk);
            again = ld_req;
        end while (again);
        check(t == exp_trk, "R7 reload track", t, exp_trk);
        loaded_trk = t;
        exp_ptr = 0;
    endtask

    initial begin
        #(4 * 150000);
        errs++; checks++;
        $display("FAIL watchdog: all requirements, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ld_req == 1'b1, "R1 req", int'(ld_req), 1);
        check(ld_track == 6'd0, "R1 track", int'(ld_track), 0);
        check(ld_block == 1'b0, "R1 block", int'(ld_block), 0);
        check(head_track == 6'd0, "R1 head", int'(head_track), 0);
        check(io_rd_data == 8'd0, "R1 data", int'(io_rd_data), 0);
        io(9);
        read_data(1'b0, "R8 read while loading");
        check(ld_req == 1'b1, "R5 req stays", int'(ld_req), 1);
        io(8);
        serve_track(0);
        // R10 motor off
        repeat (3) read_data(1'b0, "R10 motor off");
        io(9);
        repeat (10) read_data(1'b1, "R9 read");
        // R4 / R11 other offsets change nothing
        io(13); check(io_rd_data == 8'd0, "R11 other offset", int'(io_rd_data), 0);
        io(10); io(11); io(14); io(15);
        check(head_track == 6'd0, "R4 head unchanged", int'(head_track), 0);
        check(ld_req == 1'b0, "R4 no reload", int'(ld_req), 0);
        read_data(1'b1, "R4 pointer kept");
        io(8);
        read_data(1'b0, "R10 motor off mid");
        io(9);
        read_data(1'b1, "R10 pointer held");
        // R9 wrap
        repeat (LEN + 3) read_data(1'b1, "R9 wrap");
        // R3 off events and foreign phases
        phase_op(1, 1'b0); phase_op(2, 1'b1); phase_op(0, 1'b0);
        // R2 steps out, R7 change during load
        step_up(); step_up();
        read_data(1'b0, "R8 zero in reload");
        step_up(); step_up();
        serve_track(2);
        read_data(1'b1, "R9 restart at 0");
        // R3 clamp at 0
        repeat (6) step_down();
        check(exp_half == 0, "R3 clamp low model", exp_half, 0);
        step_down();
        serve_track(0);
        // R2 clamp at top
        repeat (75) step_up();
        check(int'(head_track) == 34, "R2 clamp high", int'(head_track), 34);
        serve_track(34);
        repeat (4) read_data(1'b1, "R9 top track");
        // random phase events
        repeat (300) phase_op(int'($urandom % 4), 1'($urandom % 2));
        serve_track(exp_half / 2);
        repeat (20) read_data(1'b1, "R9 random track");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule